// File: doc/BRIEF.md
# Multi-format TDM audio serial transmitter

This block shifts four 24-bit two's-complement audio words out on one or two serial data pins. The bit clock and frame clock come from outside and are inputs. All output bits change on the falling edge of the bit clock.

Two mode pins pick the layout:
- A plain two-channel-per-pin layout of 64 bit periods.
- A 256-bit time-division frame.
- A 128-bit time-division frame.

A format pin picks the alignment:
- Left-justified, where the frame starts on a rising frame-clock edge.
- I2S-style, where the frame starts on a falling edge and the data comes one bit period later.

In the 256-bit layout, two devices can be chained. The second device sends its own four channels first. It then replays the four channels that it received on its TDM input during the first half of the frame.

The sample words are captured when a frame starts, so a change in the middle of a frame is not seen until the next frame. A bit-position counter restarts on every frame-clock edge of the active polarity. While the power-down input is low, both data pins are held low.

Top module: `tdm_audio_tx`

## Requirements
- R1: While `pd_n` is low, both `sdo1` and `sdo2` are 0. After `pd_n` rises, both stay 0 until the first active frame edge is seen.
- R2: Each channel uses a 32-bit-period slot. The slot carries the 24-bit word MSB first (bit 23 down to bit 0), and the 8 trailing bits are 0.
- R3: With `fmt_i2s`=0, the active frame edge is a rising `lrck`. Take the first bit-clock falling edge at which `lrck` is seen high after being low. The bit period starting at that edge (frame position 0) carries the MSB of the first slot.
- R4: With `fmt_i2s`=1, the active frame edge is a falling `lrck`. Frame position 0 is 0, and every slot starts one bit period later than in R3.
- R5: Normal mode (`tdm_on`=0, `tdm_short`=0) uses 64 frame positions. On `sdo1`, slot 0 is `ch_word[0]` and slot 1 is `ch_word[1]`. On `sdo2`, slot 0 is `ch_word[2]` and slot 1 is `ch_word[3]`. Both pins are 0 from position 64 on.
- R6: TDM256 mode (`tdm_on`=1, `tdm_short`=0) sends slots 0..3 = `ch_word[0..3]` on `sdo1`. It sends the same four slots on `sdo2`, and `sdo2` is 0 from position 128 on.
- R7: In TDM256 mode, at frame positions 128..255, `sdo1` carries the value that `tdm_in` had at the bit-clock rising edge 128 bit periods earlier.
- R8: TDM128 mode (`tdm_on`=1, `tdm_short`=1) sends slots 0..3 = `ch_word[0..3]` on `sdo1` and holds `sdo2` at 0.
- R9: The combination `tdm_on`=0 with `tdm_short`=1 is invalid, and it holds both outputs at 0.
- R10: The words are captured at the active frame edge. A change of `ch_word` after position 0 does not alter the frame being sent.
- R11: Every active frame edge restarts the frame at position 0, even one that comes before the nominal frame length. Frame-clock edges of the other polarity do not restart it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Bit clock; outputs change on its falling edge |
| pd_n | input | 1 | Active-low power-down, asynchronous |
| lrck | input | 1 | Frame clock |
| fmt_i2s | input | 1 | 1 = I2S-style alignment, 0 = left-justified |
| tdm_on | input | 1 | 1 = time-division layout, 0 = normal layout |
| tdm_short | input | 1 | With tdm_on = 1: 1 = 128-bit frame, 0 = 256-bit frame |
| ch_word | input | 4x24 | Four sample words, element 0 being the first slot |
| tdm_in | input | 1 | Serial data from an upstream device in a chain |
| sdo1 | output | 1 | First serial data output |
| sdo2 | output | 1 | Second serial data output |

## Verification
The hardest case to reach is the chain replay. Position 128 onward must carry exactly the `tdm_in` bits of the same frame's first half, so the stimulus gives `tdm_in` a distinct irregular pattern in every 256-bit frame, and each replayed bit is compared with the bit driven 128 periods earlier.

A second hard case is a frame shortened by an early active edge. A 40-period frame is cut short and followed by a full frame, which shows that the counter restarts rather than running on.

The capture rule is tested in every frame by inverting `ch_word` one bit period after the frame starts.

// File: rtl/tdm_tx_pkg.sv
`timescale 1ns/1ps
package tdm_tx_pkg;

  typedef enum logic [1:0] {
    FMT_NORM = 2'd0,
    FMT_T256 = 2'd1,
    FMT_T128 = 2'd2,
    FMT_BAD  = 2'd3
  } tx_mode_e;

  // Two mode pins to layout; a short frame without TDM is illegal.
  function automatic tx_mode_e decode_mode(input logic tdm_on, input logic tdm_short);
    if (!tdm_on) return tdm_short ? FMT_BAD : FMT_NORM;
    return tdm_short ? FMT_T128 : FMT_T256;
  endfunction

endpackage

// File: rtl/tdm_tx_frame_ctl.sv
`timescale 1ns/1ps
module tdm_tx_frame_ctl #(
  parameter int DATA_W = 24,
  parameter int NCH    = 4,
  parameter int CNT_W  = 9,
  parameter int POS_MAX = 256
) (
  input  logic                         bclk,
  input  logic                         pd_n,
  input  logic                         lrck,
  input  logic                         fmt_i2s,
  input  logic [NCH-1:0][DATA_W-1:0]   words_in,
  output logic                         start_evt,
  output logic                         cur_valid,
  output logic [CNT_W-1:0]             cur_pos,
  output logic [NCH-1:0][DATA_W-1:0]   cur_words
);

  logic                       lr_q;
  logic                       lr_vld;
  logic                       synced_q;
  logic [CNT_W-1:0]           pos_q;
  logic [NCH-1:0][DATA_W-1:0] words_q;

  // Active polarity: rising for left-justified, falling for I2S.
  assign start_evt = lr_vld && (lrck != lr_q) && (lrck == !fmt_i2s);
  assign cur_valid = start_evt || synced_q;
  assign cur_pos   = start_evt ? '0 : pos_q;
  assign cur_words = start_evt ? words_in : words_q;

  always_ff @(negedge bclk or negedge pd_n) begin
    if (!pd_n) begin
      lr_q     <= 1'b0;
      lr_vld   <= 1'b0;
      synced_q <= 1'b0;
      pos_q    <= '0;
      words_q  <= '0;
    end else begin
      lr_q   <= lrck;
      lr_vld <= 1'b1;
      if (start_evt) begin
        synced_q <= 1'b1;
        pos_q    <= CNT_W'(1);
        words_q  <= words_in;
      end else if (pos_q != CNT_W'(POS_MAX)) begin
        pos_q <= pos_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/tdm_tx_casc_dly.sv
`timescale 1ns/1ps
module tdm_tx_casc_dly #(
  parameter int DEPTH = 128
) (
  input  logic bclk,
  input  logic pd_n,
  input  logic tdm_in,
  output logic casc_bit
);

  logic [DEPTH-1:0] line_q;

  // Sampled mid-bit on the rising edge, where upstream data is stable.
  always_ff @(posedge bclk or negedge pd_n) begin
    if (!pd_n) line_q <= '0;
    else       line_q <= {line_q[DEPTH-2:0], tdm_in};
  end

  assign casc_bit = line_q[DEPTH-1];

endmodule

// File: rtl/tdm_tx_bit_sel.sv
`timescale 1ns/1ps
module tdm_tx_bit_sel
  import tdm_tx_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int SLOT_W = 32,
  parameter int NCH    = 4,
  parameter int CNT_W  = 9
) (
  input  tx_mode_e                     mode,
  input  logic                         fmt_i2s,
  input  logic                         cur_valid,
  input  logic [CNT_W-1:0]             cur_pos,
  input  logic [NCH-1:0][DATA_W-1:0]   cur_words,
  input  logic                         casc_bit,
  output logic                         nxt1,
  output logic                         nxt2
);

  localparam int SLOT_LG    = $clog2(SLOT_W);
  localparam int SL_W       = CNT_W - SLOT_LG;
  localparam int HALF       = NCH / 2;
  localparam int CASC_START = NCH * SLOT_W;

  function automatic logic slot_bit(input logic [DATA_W-1:0] w, input logic [SLOT_LG-1:0] b);
    if (int'(b) < DATA_W) return w[DATA_W-1-int'(b)];
    return 1'b0;
  endfunction

  logic [CNT_W-1:0]   q;
  logic [SL_W-1:0]    slot;
  logic [SLOT_LG-1:0] bis;
  logic               early;
  logic               casc_zone;
  logic [NCH-1:0]     chan_bit;

  assign early     = fmt_i2s && (cur_pos == '0);
  assign q         = cur_pos - CNT_W'(fmt_i2s);
  assign slot      = q[CNT_W-1:SLOT_LG];
  assign bis       = q[SLOT_LG-1:0];
  assign casc_zone = (cur_pos >= CNT_W'(CASC_START));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign chan_bit[c] = slot_bit(cur_words[c], bis);
  end

  logic own_t, own_n1, own_n2;

  always_comb begin
    own_t  = 1'b0;
    own_n1 = 1'b0;
    own_n2 = 1'b0;
    for (int c = 0; c < NCH; c++) begin
      if (slot == SL_W'(c)) own_t = chan_bit[c];
      if (c < HALF) begin
        if (slot == SL_W'(c)) own_n1 = chan_bit[c];
      end else begin
        if (slot == SL_W'(c - HALF)) own_n2 = chan_bit[c];
      end
    end
  end

  always_comb begin
    nxt1 = 1'b0;
    nxt2 = 1'b0;
    if (cur_valid && !early) begin
      unique case (mode)
        FMT_NORM: begin nxt1 = own_n1; nxt2 = own_n2; end
        FMT_T256: begin
          nxt1 = casc_zone ? casc_bit : own_t;
          nxt2 = casc_zone ? 1'b0 : own_t;
        end
        FMT_T128: begin nxt1 = own_t; nxt2 = 1'b0; end
        default:  begin nxt1 = 1'b0; nxt2 = 1'b0; end
      endcase
    end
  end

endmodule

// File: rtl/tdm_audio_tx.sv
`timescale 1ns/1ps
module tdm_audio_tx
  import tdm_tx_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int SLOT_W = 32,
  parameter int NCH    = 4
) (
  input  logic                       bclk,
  input  logic                       pd_n,
  input  logic                       lrck,
  input  logic                       fmt_i2s,
  input  logic                       tdm_on,
  input  logic                       tdm_short,
  input  logic [NCH-1:0][DATA_W-1:0] ch_word,
  input  logic                       tdm_in,
  output logic                       sdo1,
  output logic                       sdo2
);

  localparam int POS_MAX    = 2 * NCH * SLOT_W;
  localparam int CNT_W      = $clog2(POS_MAX + 1);
  localparam int CASC_DEPTH = NCH * SLOT_W;

  tx_mode_e                   mode_w;
  logic                       start_evt;
  logic                       cur_valid;
  logic [CNT_W-1:0]           cur_pos;
  logic [NCH-1:0][DATA_W-1:0] cur_words;
  logic                       casc_bit;
  logic                       nxt1, nxt2;
  logic                       sdo1_q, sdo2_q;

  assign mode_w = decode_mode(tdm_on, tdm_short);

  tdm_tx_frame_ctl #(
    .DATA_W(DATA_W), .NCH(NCH), .CNT_W(CNT_W), .POS_MAX(POS_MAX)
  ) u_frame (
    .bclk(bclk), .pd_n(pd_n), .lrck(lrck), .fmt_i2s(fmt_i2s),
    .words_in(ch_word), .start_evt(start_evt), .cur_valid(cur_valid),
    .cur_pos(cur_pos), .cur_words(cur_words)
  );

  tdm_tx_casc_dly #(.DEPTH(CASC_DEPTH)) u_casc (
    .bclk(bclk), .pd_n(pd_n), .tdm_in(tdm_in), .casc_bit(casc_bit)
  );

  tdm_tx_bit_sel #(
    .DATA_W(DATA_W), .SLOT_W(SLOT_W), .NCH(NCH), .CNT_W(CNT_W)
  ) u_sel (
    .mode(mode_w), .fmt_i2s(fmt_i2s), .cur_valid(cur_valid),
    .cur_pos(cur_pos), .cur_words(cur_words), .casc_bit(casc_bit),
    .nxt1(nxt1), .nxt2(nxt2)
  );

  always_ff @(negedge bclk or negedge pd_n) begin
    if (!pd_n) begin
      sdo1_q <= 1'b0;
      sdo2_q <= 1'b0;
    end else begin
      sdo1_q <= nxt1;
      sdo2_q <= nxt2;
    end
  end

  assign sdo1 = sdo1_q;
  assign sdo2 = sdo2_q;

endmodule

// File: rtl/tdm_tx_chk.sv
`timescale 1ns/1ps
module tdm_tx_chk
  import tdm_tx_pkg::*;
#(
  parameter int SLOT_W = 32,
  parameter int DATA_W = 24,
  parameter int CNT_W  = 9
) (
  input logic             bclk,
  input logic             pd_n,
  input logic             fmt_i2s,
  input tx_mode_e         mode_w,
  input logic             start_evt,
  input logic             cur_valid,
  input logic [CNT_W-1:0] cur_pos,
  input logic             msb0,
  input logic             sdo1,
  input logic             sdo2
);

  function automatic logic in_pad(input logic [CNT_W-1:0] p, input logic d);
    int q;
    q = int'(p) - int'(d);
    return (q >= 0) && ((q % SLOT_W) >= DATA_W);
  endfunction

  always @(posedge bclk) begin
    if (!pd_n) begin
      a_r1_pd_low: assert (!sdo1 && !sdo2);
    end
  end

  a_r1_unsynced: assert property (@(negedge bclk) disable iff (!pd_n)
    !cur_valid |=> (!sdo1 && !sdo2));

  a_r2_pad_zero: assert property (@(negedge bclk) disable iff (!pd_n)
    (cur_valid && mode_w != FMT_T256 && in_pad(cur_pos, fmt_i2s)) |=> (!sdo1 && !sdo2));

  a_r3_msb_first: assert property (@(negedge bclk) disable iff (!pd_n)
    (start_evt && !fmt_i2s && mode_w != FMT_BAD) |=> (sdo1 == $past(msb0)));

  a_r4_i2s_gap: assert property (@(negedge bclk) disable iff (!pd_n)
    (start_evt && fmt_i2s) |=> (!sdo1 && !sdo2));

  a_r8_t128_pin2: assert property (@(negedge bclk) disable iff (!pd_n)
    (mode_w == FMT_T128) |=> !sdo2);

  a_r9_bad_mode: assert property (@(negedge bclk) disable iff (!pd_n)
    (mode_w == FMT_BAD) |=> (!sdo1 && !sdo2));

endmodule

bind tdm_audio_tx tdm_tx_chk #(.SLOT_W(SLOT_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .bclk(bclk), .pd_n(pd_n), .fmt_i2s(fmt_i2s), .mode_w(mode_w),
  .start_evt(start_evt), .cur_valid(cur_valid), .cur_pos(cur_pos),
  .msb0(ch_word[0][DATA_W-1]), .sdo1(sdo1), .sdo2(sdo2)
);

// File: tb/tdm_audio_tx_test.sv
`timescale 1ns/1ps
module tdm_audio_tx_test;

  logic bclk = 1'b1;
  logic pd_n = 1'b0;
  logic lrck = 1'b0;
  logic fmt_i2s = 1'b0;
  logic tdm_on = 1'b0;
  logic tdm_short = 1'b0;
  logic [3:0][23:0] ch_word = '1;
  logic tdm_in = 1'b0;
  logic sdo1, sdo2;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic got1 [256];
  logic got2 [256];
  logic tin  [256];

  always #5 bclk = ~bclk;

  tdm_audio_tx uut (
    .bclk(bclk), .pd_n(pd_n), .lrck(lrck), .fmt_i2s(fmt_i2s),
    .tdm_on(tdm_on), .tdm_short(tdm_short), .ch_word(ch_word),
    .tdm_in(tdm_in), .sdo1(sdo1), .sdo2(sdo2)
  );

  typedef struct packed {
    logic        on;
    logic        sh;
    logic        i2s;
    logic [95:0] w;
  } vec_t;

  // w = {ch3, ch2, ch1, ch0}
  localparam vec_t VECS [8] = '{
    '{1'b0, 1'b0, 1'b0, 96'hA5A5A5_5A5A5A_7FFFFE_800001},
    '{1'b0, 1'b0, 1'b1, 96'hFFFFFF_000001_FEDCBA_123456},
    '{1'b1, 1'b0, 1'b0, 96'h0F0F0F_C3C3C3_800000_7FFFFF},
    '{1'b1, 1'b0, 1'b1, 96'h654321_ABCDEF_000000_FFFFFF},
    '{1'b1, 1'b1, 1'b0, 96'h111111_888888_3C3C3C_E00007},
    '{1'b1, 1'b1, 1'b1, 96'h800000_000001_AAAAAA_555555},
    '{1'b1, 1'b0, 1'b0, 96'h000000_FFFFFF_000000_FFFFFF},
    '{1'b0, 1'b0, 1'b1, 96'h7FFFFF_800000_C00003_246813}
  };

  // Expected bit at frame position p, built slot by slot from the requirements.
  function automatic logic exp_bit(int pin, int p, logic on, logic sh, logic i2s, logic [95:0] w);
    int q, s, b, ch;
    logic [23:0] word;
    if (!on && sh) return 1'b0;                                 // R9
    if (on && !sh && pin == 1 && p >= 128) return tin[p-128];   // R7
    q = i2s ? p - 1 : p;                                        // R3 / R4
    if (q < 0) return 1'b0;
    s = q / 32;
    b = q % 32;
    if (b >= 24) return 1'b0;                                   // R2 padding
    if (!on) begin                                              // R5
      if (s >= 2) return 1'b0;
      ch = (pin == 1) ? s : s + 2;
    end else begin                                              // R6 / R8
      if (s >= 4) return 1'b0;
      if (sh && pin == 2) return 1'b0;
      ch = s;
    end
    word = w[ch*24 +: 24];
    return word[23-b];
  endfunction

  task automatic step(input logic lr, input logic ti);
    lrck = lr;
    tdm_in = ti;
    @(posedge bclk);
    #1;
  endtask

  task automatic check(input logic ok, input string msg, input logic [1:0] act, input logic [1:0] ex);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %b expected %b", msg, act, ex);
    end
  endtask

  task automatic run_frame(input int idx, input logic on, input logic sh, input logic i2s,
                           input logic [95:0] w, input int pre, input int len, input int hi_len,
                           input bit do_check, input string tag);
    logic act_lv;
    act_lv = !i2s;
    tdm_on = on;
    tdm_short = sh;
    fmt_i2s = i2s;
    ch_word = w;
    for (int k = 0; k < pre; k++) step(!act_lv, 1'b0);
    for (int p = 0; p < len; p++) begin
      tin[p] = (((p * 5) + idx) % 7) < 3;
      if (p == 1) ch_word = ~w;      // R10: mid-frame update must not tear
      lrck = (p < hi_len) ? act_lv : !act_lv;
      tdm_in = tin[p];
      @(posedge bclk);
      #1;
      got1[p] = sdo1;
      got2[p] = sdo2;
    end
    if (do_check) begin
      for (int pin = 1; pin <= 2; pin++) begin
        int bad;
        logic g, e, bg, be;
        bad = -1;
        bg = 1'b0;
        be = 1'b0;
        for (int p = 0; p < len; p++) begin
          e = exp_bit(pin, p, on, sh, i2s, w);
          g = (pin == 1) ? got1[p] : got2[p];
          if (g !== e && bad < 0) begin bad = p; bg = g; be = e; end
        end
        checks++;
        if (bad >= 0) begin
          errors++;
          $display("FAIL %s R2 R10 frame %0d pin %0d pos %0d actual %b expected %b",
                   tag, idx, pin, bad, bg, be);
        end
      end
    end
  endtask

  function automatic string tag_of(logic on, logic sh, logic i2s);
    string t;
    if (!on) t = "R5 R11";
    else if (sh) t = "R8";
    else t = "R6 R7";
    return {t, i2s ? " R4" : " R3"};
  endfunction

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(posedge bclk);
    #1;
    // R1: power-down holds outputs low even with the frame clock moving
    for (int k = 0; k < 6; k++) step(k[1], 1'b1);
    check(sdo1 === 1'b0 && sdo2 === 1'b0, "R1 power-down outputs",
          {sdo1, sdo2}, 2'b00);
    step(1'b1, 1'b1);
    check(sdo1 === 1'b0 && sdo2 === 1'b0, "R1 power-down outputs later",
          {sdo1, sdo2}, 2'b00);

    // R1: released, but no active edge yet
    pd_n = 1'b1;
    begin
      logic any;
      any = 1'b0;
      for (int k = 0; k < 8; k++) begin
        step(1'b0, 1'b1);
        any = any | sdo1 | sdo2;
      end
      check(any === 1'b0, "R1 idle before first frame edge", {1'b0, any}, 2'b00);
    end

    // Vector table
    for (int i = 0; i < 8; i++) begin
      int len, hi;
      len = !VECS[i].on ? 64 : (VECS[i].sh ? 128 : 256);
      hi  = len / 2;
      run_frame(i, VECS[i].on, VECS[i].sh, VECS[i].i2s, VECS[i].w, 4, len, hi, 1'b1,
                tag_of(VECS[i].on, VECS[i].sh, VECS[i].i2s));
    end

    // R9: invalid mode combination
    run_frame(20, 1'b0, 1'b1, 1'b0, 96'hFFFFFF_FFFFFF_FFFFFF_FFFFFF, 4, 64, 32, 1'b1, "R9");

    // R11: early active edge cuts a frame short, next frame restarts at position 0
    run_frame(21, 1'b1, 1'b1, 1'b0, 96'h13579B_2468AC_FDB975_ECA864, 4, 40, 20, 1'b1, "R11 short");
    run_frame(22, 1'b1, 1'b1, 1'b0, 96'h9ABCDE_F01234_56789A_BCDEF0, 0, 128, 64, 1'b1, "R11 restart");

    // R1: power-down in the middle of a frame
    run_frame(23, 1'b1, 1'b0, 1'b0, 96'hFFFFFF_FFFFFF_FFFFFF_FFFFFF, 4, 10, 128, 1'b0, "R1");
    pd_n = 1'b0;
    #2;
    check(sdo1 === 1'b0 && sdo2 === 1'b0, "R1 power-down mid-frame",
          {sdo1, sdo2}, 2'b00);
    @(posedge bclk);
    #1;
    step(1'b0, 1'b1);
    step(1'b1, 1'b1);
    check(sdo1 === 1'b0 && sdo2 === 1'b0, "R1 power-down held",
          {sdo1, sdo2}, 2'b00);
    pd_n = 1'b1;

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule